// File: doc/BRIEF.md
# Block-Transfer Configuration Register Slave

This block is a two-wire serial slave that lets a bus host load and read back a small bank of 8-bit configuration registers. Every transfer is a block transfer that starts at register 0, so there is no register pointer. Both bus lines are sampled on a fast system clock. Each line passes through a synchronizer and a majority-free glitch filter. Start and stop conditions are then detected from the filtered levels. The slave drives SDA only as an open-drain pull-down: its single output asks the pad to pull the line low.

On a write, the host addresses the slave and sends two bytes that the slave acknowledges and throws away. The first is a command code and the second is a count. The data bytes that follow fill register 0, register 1 and so on upward. The host may end the transfer after any whole byte. On a read, the slave returns the number of registers first and then the register contents in ascending order, for as long as the host acknowledges. The register bank drives a wide parallel output that the rest of the chip decodes.

Top module: `blkcfg_slave`

## Requirements
- R1: After reset, `regs_o` holds the power-on defaults (register 0 in bits 7:0 up to register 5 in bits 47:40: 00, 1D, FF, FF, DB, 00 hex) and `sda_oe` is 0.
- R2: An address byte of D2 hex (write) or D3 hex (read), sent MSB first with the direction in bit 0, is acknowledged by pulling SDA low during the ninth clock. Any other address gets no acknowledge, and the slave ignores all later bytes until the next start.
- R3: In a write, the first two bytes after the address are acknowledged, and their values never reach any register.
- R4: In a write, the third and later bytes after the address are acknowledged and stored into register 0, 1, 2, ... in that order.
- R5: A stop after any whole byte leaves the registers not yet reached at their previous values. Registers change only when a data byte completes.
- R6: Data bytes beyond register 5 are acknowledged and discarded.
- R7: In a read, the slave sends the count 6 first and then registers 0 to 5, each MSB first. SDA changes only while SCL is low.
- R8: The slave releases SDA (`sda_oe` = 0) after the host does not acknowledge a read byte, and on any stop condition.
- R9: A pulse shorter than FILT_LEN system clocks on SCL or SDA has no effect on the transfer.
- R10: A repeated start releases SDA and restarts the address phase, so a write may be followed directly by a read without a stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, many times faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND level) |
| sda_oe | output | 1 | 1 asks the pad to pull SDA low |
| regs_o | output | NUM_REGS*8 (48) | Register contents, register 0 in the low byte |

## Verification
The hardest case to reach from the ports is a short spike on a bus line. A spike on SCL during its low phase, or on SDA while SCL is high, would look like a false clock, start or stop if it passed the filter. The bench drives a host model that places two-clock pulses on both lines in every data bit of one write. It then checks that the acknowledges and the stored values are the same as in a clean transfer. A repeated start, used directly after a write, also checks that the read path begins again from the count byte.

// File: rtl/blkcfg_pkg.sv
package blkcfg_pkg;
  localparam int BYTE_W = 8;

  // Link-layer phases of the slave engine
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RACK,
    ST_TX,
    ST_TACK
  } link_st_e;

  // Power-on contents, register 0 in the low byte
  localparam logic [6*BYTE_W-1:0] DEFAULT_REGS = 48'h00DB_FFFF_1D00;
endpackage

// File: rtl/blkcfg_deglitch.sv
module blkcfg_deglitch #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    win_q;
  logic                   out_q;

  // Output follows the input only after FILT_LEN equal samples
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      win_q  <= '1;
      out_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      win_q  <= {win_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      if (&win_q)       out_q <= 1'b1;
      else if (~|win_q) out_q <= 1'b0;
    end
  end

  assign dout = out_q;
endmodule

// File: rtl/blkcfg_regbank.sv
module blkcfg_regbank import blkcfg_pkg::*; #(
  parameter int                          NUM_REGS   = 6,
  parameter logic [NUM_REGS*BYTE_W-1:0]  RESET_VALS = DEFAULT_REGS
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [$clog2(NUM_REGS)-1:0]  wr_idx,
  input  logic [BYTE_W-1:0]            wr_data,
  output logic [NUM_REGS*BYTE_W-1:0]   regs_o
);
  localparam int IDX_W = $clog2(NUM_REGS);

  logic [NUM_REGS*BYTE_W-1:0] regs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      regs_q <= RESET_VALS;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (wr_idx == IDX_W'(i)) regs_q[i*BYTE_W +: BYTE_W] <= wr_data;
      end
    end
  end

  assign regs_o = regs_q;
endmodule

// File: rtl/blkcfg_engine.sv
module blkcfg_engine import blkcfg_pkg::*; #(
  parameter int         NUM_REGS = 6,
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         scl_f,
  input  logic                         sda_f,
  input  logic [NUM_REGS*BYTE_W-1:0]   regs_flat,
  output logic                         sda_oe,
  output logic                         wr_en,
  output logic [$clog2(NUM_REGS)-1:0]  wr_idx,
  output logic [BYTE_W-1:0]            wr_data,
  output logic                         start_det,
  output logic                         stop_det
);
  localparam int                 IDX_W      = $clog2(NUM_REGS);
  localparam int                 CNT_W      = $clog2(NUM_REGS + 3) + 1;
  localparam logic [CNT_W-1:0]   FIRST_DATA = CNT_W'(2);
  localparam logic [CNT_W-1:0]   END_DATA   = CNT_W'(NUM_REGS + 2);
  localparam logic [CNT_W-1:0]   CNT_MAX    = '1;
  localparam logic [BYTE_W-1:0]  COUNT_BYTE = BYTE_W'(NUM_REGS);

  link_st_e           st;
  logic               scl_q, sda_q, scl_rise, scl_fall;
  logic [3:0]         bit_cnt;
  logic [BYTE_W-1:0]  rx_sh, tx_sh, rd_byte;
  logic [CNT_W-1:0]   byte_cnt;
  logic               is_addr, rd_mode, host_ack;

  // Edge and condition detection on the filtered lines
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_det = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;

  // Next byte of a read: byte_cnt 1..NUM_REGS selects a register
  always_comb begin
    rd_byte = '1;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (byte_cnt == CNT_W'(i + 1)) rd_byte = regs_flat[i*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      sda_oe   <= 1'b0;
      bit_cnt  <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      byte_cnt <= '0;
      is_addr  <= 1'b0;
      rd_mode  <= 1'b0;
      host_ack <= 1'b0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        st       <= ST_RX;
        bit_cnt  <= '0;
        byte_cnt <= '0;
        is_addr  <= 1'b1;
        sda_oe   <= 1'b0;
      end else if (stop_det) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise) begin
              rx_sh   <= {rx_sh[BYTE_W-2:0], sda_f};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              bit_cnt <= '0;
              if (is_addr) begin
                is_addr <= 1'b0;
                if (rx_sh[7:1] == DEV_ADDR) begin
                  rd_mode <= rx_sh[0];
                  sda_oe  <= 1'b1;
                  st      <= ST_RACK;
                end else begin
                  st <= ST_IDLE;
                end
              end else begin
                sda_oe <= 1'b1;
                st     <= ST_RACK;
                if (byte_cnt >= FIRST_DATA && byte_cnt < END_DATA) begin
                  wr_en   <= 1'b1;
                  wr_idx  <= IDX_W'(byte_cnt - FIRST_DATA);
                  wr_data <= rx_sh;
                end
                if (byte_cnt != CNT_MAX) byte_cnt <= byte_cnt + 1'b1;
              end
            end
          end
          ST_RACK: begin
            if (scl_fall) begin
              if (rd_mode) begin
                st       <= ST_TX;
                tx_sh    <= COUNT_BYTE;
                sda_oe   <= ~COUNT_BYTE[BYTE_W-1];
                byte_cnt <= CNT_W'(1);
              end else begin
                st     <= ST_RX;
                sda_oe <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bit_cnt == 4'd7) begin
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
                st      <= ST_TACK;
              end else begin
                bit_cnt <= bit_cnt + 4'd1;
                tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b1};
                sda_oe  <= ~tx_sh[BYTE_W-2];
              end
            end
          end
          ST_TACK: begin
            if (scl_rise) begin
              host_ack <= ~sda_f;
            end else if (scl_fall) begin
              if (host_ack) begin
                st     <= ST_TX;
                tx_sh  <= rd_byte;
                sda_oe <= ~rd_byte[BYTE_W-1];
                if (byte_cnt != CNT_MAX) byte_cnt <= byte_cnt + 1'b1;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/blkcfg_slave.sv
module blkcfg_slave import blkcfg_pkg::*; #(
  parameter int                          NUM_REGS    = 6,
  parameter logic [6:0]                  DEV_ADDR    = 7'h69,
  parameter int                          SYNC_STAGES = 2,
  parameter int                          FILT_LEN    = 3,
  parameter logic [NUM_REGS*BYTE_W-1:0]  RESET_VALS  = DEFAULT_REGS
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        scl_i,
  input  logic                        sda_i,
  output logic                        sda_oe,
  output logic [NUM_REGS*BYTE_W-1:0]  regs_o
);
  localparam int IDX_W   = $clog2(NUM_REGS);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw_lines, flt_lines;
  logic               scl_flt, sda_flt;
  logic               wr_en, start_det, stop_det;
  logic [IDX_W-1:0]   wr_idx;
  logic [BYTE_W-1:0]  wr_data;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    blkcfg_deglitch #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_deglitch (
      .clk (clk),
      .rst (rst),
      .din (raw_lines[g]),
      .dout(flt_lines[g])
    );
  end

  assign scl_flt = flt_lines[0];
  assign sda_flt = flt_lines[1];

  blkcfg_engine #(
    .NUM_REGS(NUM_REGS),
    .DEV_ADDR(DEV_ADDR)
  ) u_engine (
    .clk      (clk),
    .rst      (rst),
    .scl_f    (scl_flt),
    .sda_f    (sda_flt),
    .regs_flat(regs_o),
    .sda_oe   (sda_oe),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  blkcfg_regbank #(
    .NUM_REGS  (NUM_REGS),
    .RESET_VALS(RESET_VALS)
  ) u_regbank (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_data(wr_data),
    .regs_o (regs_o)
  );
endmodule

// File: rtl/blkcfg_checker.sv
module blkcfg_checker #(
  parameter int                    NUM_REGS   = 6,
  parameter logic [NUM_REGS*8-1:0] RESET_VALS = '0
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    scl_f,
  input logic                    sda_oe,
  input logic                    wr_en,
  input logic                    start_det,
  input logic                    stop_det,
  input logic [NUM_REGS*8-1:0]   regs_o
);
  p_reset_defaults_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (regs_o == RESET_VALS && !sda_oe));

  p_regs_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(regs_o));

  p_sda_steady_scl_high_r7: assert property (@(posedge clk) disable iff (rst)
    (scl_f && $past(scl_f)) |-> $stable(sda_oe));

  p_stop_release_r8: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);

  p_restart_release_r10: assert property (@(posedge clk) disable iff (rst)
    start_det |=> !sda_oe);
endmodule

bind blkcfg_slave blkcfg_checker #(
  .NUM_REGS  (NUM_REGS),
  .RESET_VALS(RESET_VALS)
) u_blkcfg_checker (
  .clk      (clk),
  .rst      (rst),
  .scl_f    (scl_flt),
  .sda_oe   (sda_oe),
  .wr_en    (wr_en),
  .start_det(start_det),
  .stop_det (stop_det),
  .regs_o   (regs_o)
);

// File: tb/test_blkcfg_slave.sv
module test_blkcfg_slave;
  localparam int Q = 12;  // quarter of an SCL period in system clocks

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl = 1'b1;
  logic        sda_h = 1'b1;
  logic        sda_oe;
  logic [47:0] regs_o;
  logic        sda_line;

  int checks = 0;
  int errors = 0;
  bit model_on = 1'b0;
  int settle = 0;
  logic [7:0] exp_regs [6];
  logic [7:0] old_regs [6];
  logic [7:0] wq [$];

  assign sda_line = sda_h & ~sda_oe;

  always #10 clk = ~clk;

  blkcfg_slave i_blkcfg_slave (
    .clk   (clk),
    .rst   (rst),
    .scl_i (scl),
    .sda_i (sda_line),
    .sda_oe(sda_oe),
    .regs_o(regs_o)
  );

  task automatic tk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // Reference register model, compared on every clock (R4, R5)
  always @(negedge clk) begin
    if (model_on) begin
      for (int i = 0; i < 6; i++) begin
        checks++;
        if (regs_o[8*i +: 8] !== exp_regs[i] &&
            !(settle > 0 && regs_o[8*i +: 8] === old_regs[i])) begin
          errors++;
          $display("FAIL R5 reg%0d got %h exp %h", i, regs_o[8*i +: 8], exp_regs[i]);
        end
      end
      if (settle > 0) settle--;
    end
  end

  task automatic commit(input int slot, input logic [7:0] v);
    for (int i = 0; i < 6; i++) old_regs[i] = exp_regs[i];
    exp_regs[slot] = v;
    settle = 24;
  endtask

  task automatic send_bit(input logic b, input bit glitch, output logic seen);
    tk(Q);
    sda_h = b;
    if (glitch) begin
      tk(3); scl = 1'b1; tk(2); scl = 1'b0; tk(Q - 4);
    end else begin
      tk(Q + 1);
    end
    scl = 1'b1;
    tk(Q);
    seen = sda_line;
    if (glitch) begin
      tk(4); sda_h = ~b; tk(2); sda_h = b; tk(Q - 5);
    end else begin
      tk(Q + 1);
    end
    scl = 1'b0;
  endtask

  task automatic bus_start();
    tk(2 * Q); sda_h = 1'b0; tk(2 * Q); scl = 1'b0;
  endtask

  task automatic bus_restart();
    tk(Q); sda_h = 1'b1; tk(Q + 1); scl = 1'b1; tk(2 * Q); sda_h = 1'b0; tk(2 * Q); scl = 1'b0;
  endtask

  task automatic bus_stop();
    tk(Q); sda_h = 1'b0; tk(Q + 1); scl = 1'b1; tk(2 * Q); sda_h = 1'b1; tk(2 * Q);
  endtask

  task automatic write_byte(input logic [7:0] v, input bit glitch, input int slot, output bit ack);
    logic s;
    for (int i = 7; i >= 0; i--) send_bit(v[i], glitch, s);
    if (slot >= 0) commit(slot, v);
    send_bit(1'b1, 1'b0, s);
    ack = ~s;
  endtask

  task automatic read_byte(input bit host_ack, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      send_bit(1'b1, 1'b0, s);
      v[i] = s;
    end
    send_bit(~host_ack, 1'b0, s);
  endtask

  // Write transfer with the data in wq
  task automatic wr_txn(input bit glitch, input bit do_stop);
    bit ack;
    bus_start();
    write_byte(8'hD2, 1'b0, -1, ack); chk("R2 write address ack", 32'(ack), 32'd1);
    write_byte(8'h02, 1'b0, -1, ack); chk("R3 command byte ack", 32'(ack), 32'd1);
    write_byte(8'hE7, 1'b0, -1, ack); chk("R3 count byte ack", 32'(ack), 32'd1);
    for (int i = 0; i < wq.size(); i++) begin
      write_byte(wq[i], glitch, (i < 6) ? i : -1, ack);
      if (i < 6) chk("R4 data byte ack", 32'(ack), 32'd1);
      else       chk("R6 extra byte ack", 32'(ack), 32'd1);
    end
    if (do_stop) begin
      bus_stop();
      chk("R8 released after stop", 32'(sda_oe), 32'd0);
    end
  endtask

  // Read transfer: count byte, then n registers, last one not acknowledged
  task automatic rd_txn(input int n, input bit restart);
    bit ack;
    logic [7:0] v;
    if (restart) bus_restart(); else bus_start();
    write_byte(8'hD3, 1'b0, -1, ack); chk("R2 read address ack", 32'(ack), 32'd1);
    read_byte(n > 0, v); chk("R7 count byte", 32'(v), 32'd6);
    for (int i = 0; i < n; i++) begin
      read_byte(i < n - 1, v);
      chk($sformatf("R7 read reg%0d", i), 32'(v), 32'(exp_regs[i]));
    end
    tk(Q);
    chk("R8 released after host nack", 32'(sda_oe), 32'd0);
    bus_stop();
  endtask

  initial begin
    bit ack;
    exp_regs = '{8'h00, 8'h1D, 8'hFF, 8'hFF, 8'hDB, 8'h00};
    old_regs = exp_regs;
    tk(8);
    rst = 1'b0;
    tk(2);
    chk("R1 reset regs", 32'(regs_o[31:0]), 32'hFFFF_1D00);
    chk("R1 reset regs high", 32'(regs_o[47:32]), 32'h0000_00DB);
    chk("R1 reset sda_oe", 32'(sda_oe), 32'd0);
    model_on = 1'b1;

    // Reads of the default contents
    rd_txn(6, 1'b0);

    // Full write, then read back (R3: reg0 holds the first data byte)
    wq = {8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
    wr_txn(1'b0, 1'b1);
    chk("R3 reg0 not command or count", 32'(regs_o[7:0]), 32'h11);
    rd_txn(6, 1'b0);

    // Partial write stopped after two bytes
    wq = {8'hA0, 8'hB1};
    wr_txn(1'b0, 1'b1);
    chk("R5 reg2..5 unchanged", 32'(regs_o[47:16]), 32'h6655_4433);
    chk("R4 reg0..1 written", 32'(regs_o[15:0]), 32'hB1A0);

    // Over-length write
    wq = {8'hC0, 8'hC1, 8'hC2, 8'hC3, 8'hC4, 8'hC5, 8'hC6, 8'hC7};
    wr_txn(1'b0, 1'b1);
    chk("R6 reg5 keeps sixth byte", 32'(regs_o[47:40]), 32'hC5);
    rd_txn(3, 1'b0);

    // Foreign address: no ack, following bytes ignored
    bus_start();
    write_byte(8'hA4, 1'b0, -1, ack); chk("R2 foreign address nack", 32'(ack), 32'd0);
    write_byte(8'h02, 1'b0, -1, ack); chk("R2 ignored byte nack", 32'(ack), 32'd0);
    write_byte(8'h99, 1'b0, -1, ack); chk("R2 ignored data nack", 32'(ack), 32'd0);
    bus_stop();
    chk("R2 reg0 untouched", 32'(regs_o[7:0]), 32'hC0);

    // Short pulses on both lines in every data bit
    wq = {8'h5A, 8'hA5, 8'h0F};
    wr_txn(1'b1, 1'b1);
    chk("R9 glitched bytes stored", 32'(regs_o[23:0]), 32'h0FA55A);
    chk("R9 later regs unchanged", 32'(regs_o[47:24]), 32'hC5C4C3);

    // Write then repeated start into a read
    wq = {8'h77};
    wr_txn(1'b0, 1'b0);
    rd_txn(2, 1'b1);
    chk("R10 reg0 after restart read", 32'(regs_o[7:0]), 32'h77);

    // Read ended right after the count byte
    rd_txn(0, 1'b0);

    tk(40);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog (all requirements) got timeout exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule